// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Condition Flags

This block is the arithmetic part of a machine that has a single working register R. In each cycle it takes an operation code, one operand read from memory and the current value of R. It then produces, in the same cycle, a result word and an indicator that says where the result should be written: back to the register or to the memory cell the operand came from. Memory sequencing and instruction decode sit outside the block. The surrounding sequencer uses the result and the indicator to schedule the write-back.

The block also holds three condition flags: greater, equal and less. Only a compare operation changes them. A compare weighs the memory operand against R as signed 16-bit numbers and writes no data. The flags keep their value through any number of other operations, so a later conditional branch can read them. Arithmetic wraps modulo 2^W and there is no overflow signal.

Top module: `acc_cc_alu`

## Requirements
- R1: With opValid=1 and opSel=0 (add), result equals memOperand plus regR modulo 2^16, resValid=1 and destIsMem=0, all in the same cycle.
- R2: With opValid=1 and opSel=1 (subtract), result equals regR minus memOperand modulo 2^16, resValid=1 and destIsMem=0.
- R3: With opValid=1 and opSel=2 (increment), result equals memOperand plus one modulo 2^16, resValid=1 and destIsMem=1.
- R4: With opValid=1 and opSel=3 (decrement), result equals memOperand minus one modulo 2^16, resValid=1 and destIsMem=1.
- R5: With opValid=1 and opSel=4 (clear), result is zero, resValid=1 and destIsMem=1.
- R6: With opValid=1 and opSel=5 (compare), after the next rising clock edge exactly one flag is set. flagGt is set when memOperand is greater than regR, flagEq when they are equal, and flagLt when memOperand is less than regR. The comparison treats both operands as signed two's complement.
- R7: A compare writes no data: during it resValid=0, destIsMem=0 and result is zero.
- R8: The flags keep their value across every clock edge where a compare is not issued. This covers all other codes, the reserved codes, and any cycle with opValid=0.
- R9: Reset is active-low and asynchronous. It forces flagGt, flagEq and flagLt to 0. At any time at most one flag is set.
- R10: Reserved codes opSel=6 and opSel=7, and any cycle with opValid=0, give resValid=0, destIsMem=0 and result zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags update on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | An operation is issued this cycle |
| opSel | input | 3 | Operation code (0 add, 1 sub, 2 inc, 3 dec, 4 clr, 5 cmp, 6-7 reserved) |
| memOperand | input | W (16) | Operand read from memory |
| regR | input | W (16) | Current value of the working register |
| result | output | W (16) | Computed value, zero when nothing is written |
| resValid | output | 1 | result must be written back |
| destIsMem | output | 1 | 1: write to the memory cell, 0: write to R |
| flagGt | output | 1 | Memory operand was greater than R at the last compare |
| flagEq | output | 1 | Operands were equal at the last compare |
| flagLt | output | 1 | Memory operand was less than R at the last compare |

## Verification
The data result has no register in its path. A wrong operand selection, carry-in or destination decode therefore shows on result, resValid or destIsMem in the same cycle the code is applied. The flag register is the only state in the block. A wrong compare, a wrong signed/unsigned choice or a spurious load shows on the flag pins one edge after the offending cycle. The bench crosses every opcode with operand pairs around zero, the sign boundary and the wrap points. Running the sweep again with opValid low exposes a flag that changes when it should hold.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_INC  = 3'd2,
    OP_DEC  = 3'd3,
    OP_CLR  = 3'd4,
    OP_CMP  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } aluOp_e;

  typedef enum logic [1:0] {
    A_ZERO = 2'd0,
    A_MEM  = 2'd1,
    A_REG  = 2'd2
  } aSel_e;

  typedef enum logic [1:0] {
    B_ZERO = 2'd0,
    B_REG  = 2'd1,
    B_NMEM = 2'd2,
    B_ONES = 2'd3
  } bSel_e;

  typedef struct packed {
    aSel_e aSel;
    bSel_e bSel;
    logic  carryIn;
    logic  wrData;
    logic  toMem;
    logic  ldFlags;
  } aluStrobe_t;

  localparam int FLAG_GT = 2;
  localparam int FLAG_EQ = 1;
  localparam int FLAG_LT = 0;

endpackage

// File: rtl/acc_alu_ctrl.sv
module acc_alu_ctrl
  import acc_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [2:0] opSel,
  output aluStrobe_t strobe
);

  aluOp_e opCode;
  assign opCode = aluOp_e'(opSel);

  always_comb begin
    strobe = '{aSel: A_ZERO, bSel: B_ZERO, carryIn: 1'b0,
               wrData: 1'b0, toMem: 1'b0, ldFlags: 1'b0};
    if (opValid) begin
      case (opCode)
        OP_ADD: begin
          strobe.aSel   = A_MEM;
          strobe.bSel   = B_REG;
          strobe.wrData = 1'b1;
        end
        OP_SUB: begin
          strobe.aSel    = A_REG;
          strobe.bSel    = B_NMEM;
          strobe.carryIn = 1'b1;
          strobe.wrData  = 1'b1;
        end
        OP_INC: begin
          strobe.aSel    = A_MEM;
          strobe.carryIn = 1'b1;
          strobe.wrData  = 1'b1;
          strobe.toMem   = 1'b1;
        end
        OP_DEC: begin
          strobe.aSel   = A_MEM;
          strobe.bSel   = B_ONES;
          strobe.wrData = 1'b1;
          strobe.toMem  = 1'b1;
        end
        OP_CLR: begin
          strobe.wrData = 1'b1;
          strobe.toMem  = 1'b1;
        end
        OP_CMP: begin
          strobe.ldFlags = 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R7: a compare loads flags and never requests a data write
  p_cmp_nowrite_r7: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 3'd5) |-> (!strobe.wrData && !strobe.toMem && strobe.ldFlags));

  // R10: nothing is requested while idle
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |-> (!strobe.wrData && !strobe.ldFlags && !strobe.toMem));

  // R3: a memory destination only comes with a data write
  p_mem_needs_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.toMem |-> strobe.wrData);

endmodule

// File: rtl/acc_alu_dp.sv
module acc_alu_dp
  import acc_alu_pkg::*;
#(
  parameter int W          = 16,
  parameter bit SIGNED_CMP = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  aluStrobe_t   strobe,
  input  logic [W-1:0] memOperand,
  input  logic [W-1:0] regR,
  output logic [W-1:0] result,
  output logic [2:0]   flags
);

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] ZERO_W   = {W{1'b0}};

  logic [W-1:0] aOp;
  logic [W-1:0] bOp;
  logic [W-1:0] sum;
  logic         memGt;
  logic         memEq;
  logic         memLt;
  logic [2:0]   ccReg;

  always_comb begin
    case (strobe.aSel)
      A_MEM:   aOp = memOperand;
      A_REG:   aOp = regR;
      default: aOp = ZERO_W;
    endcase
  end

  always_comb begin
    case (strobe.bSel)
      B_REG:   bOp = regR;
      B_NMEM:  bOp = ~memOperand;
      B_ONES:  bOp = ALL_ONES;
      default: bOp = ZERO_W;
    endcase
  end

  assign sum    = aOp + bOp + {{(W-1){1'b0}}, strobe.carryIn};
  assign result = strobe.wrData ? sum : ZERO_W;

  generate
    if (SIGNED_CMP) begin : g_signedCmp
      assign memGt = $signed(memOperand) > $signed(regR);
      assign memLt = $signed(memOperand) < $signed(regR);
    end else begin : g_unsignedCmp
      assign memGt = memOperand > regR;
      assign memLt = memOperand < regR;
    end
  endgenerate

  assign memEq = (memOperand == regR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ccReg <= 3'b000;
    end else if (strobe.ldFlags) begin
      ccReg[FLAG_GT] <= memGt;
      ccReg[FLAG_EQ] <= memEq;
      ccReg[FLAG_LT] <= memLt;
    end
  end

  assign flags = ccReg;

  // R6: a compare leaves exactly one flag set
  p_cmp_onehot_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ldFlags |=> ($countones(ccReg) == 1));

  // R8: flags hold when no compare is loaded
  p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.ldFlags |=> $stable(ccReg));

  // R9: never more than one flag
  p_flags_onehot0_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ccReg));

  // R9: reset clears the flags
  p_reset_clear_r9: assert property (@(posedge clk)
    !rstN |-> (ccReg == 3'b000));

endmodule

// File: rtl/acc_cc_alu.sv
module acc_cc_alu
  import acc_alu_pkg::*;
#(
  parameter int W          = 16,
  parameter bit SIGNED_CMP = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         opValid,
  input  logic [2:0]   opSel,
  input  logic [W-1:0] memOperand,
  input  logic [W-1:0] regR,
  output logic [W-1:0] result,
  output logic         resValid,
  output logic         destIsMem,
  output logic         flagGt,
  output logic         flagEq,
  output logic         flagLt
);

  aluStrobe_t strobe;
  logic [2:0] flags;

  acc_alu_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .opValid (opValid),
    .opSel   (opSel),
    .strobe  (strobe)
  );

  acc_alu_dp #(.W(W), .SIGNED_CMP(SIGNED_CMP)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .memOperand (memOperand),
    .regR       (regR),
    .result     (result),
    .flags      (flags)
  );

  assign resValid  = strobe.wrData;
  assign destIsMem = strobe.toMem;
  assign flagGt    = flags[FLAG_GT];
  assign flagEq    = flags[FLAG_EQ];
  assign flagLt    = flags[FLAG_LT];

  // R1: add result goes to R
  p_add_sum_r1: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 3'd0) |-> (resValid && !destIsMem && result == W'(memOperand + regR)));

  // R2: subtract result goes to R
  p_sub_diff_r2: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 3'd1) |-> (resValid && !destIsMem && result == W'(regR - memOperand)));

  // R5: clear writes zero to memory
  p_clr_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 3'd4) |-> (resValid && destIsMem && result == '0));

  // R10: reserved codes write nothing
  p_rsv_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel[2:1] == 2'b11) |-> (!resValid && !destIsMem && result == '0));

endmodule

// File: tb/sim_acc_cc_alu.sv
module sim_acc_cc_alu;

  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         opValid = 1'b0;
  logic [2:0]   opSel = 3'd0;
  logic [W-1:0] memOperand = '0;
  logic [W-1:0] regR = '0;
  logic [W-1:0] result;
  logic         resValid;
  logic         destIsMem;
  logic         flagGt;
  logic         flagEq;
  logic         flagLt;

  int nChecks = 0;
  int nFails  = 0;
  logic [2:0] expFlags = 3'b000;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_cc_alu #(.W(W), .SIGNED_CMP(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel),
    .memOperand(memOperand), .regR(regR), .result(result),
    .resValid(resValid), .destIsMem(destIsMem),
    .flagGt(flagGt), .flagEq(flagEq), .flagLt(flagLt)
  );

  function automatic logic [W-1:0] sample(input int idx);
    case (idx)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h0002;
      3: return 16'h7FFF;
      4: return 16'h8000;
      5: return 16'h8001;
      6: return 16'hFFFF;
      7: return 16'hFFFE;
      8: return 16'h1234;
      default: return 16'h00FF;
    endcase
  endfunction

  function automatic string reqOf(input logic [2:0] op, input logic v);
    if (!v) return "R10";
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [W-1:0] m, input logic [W-1:0] r, input logic v);
    logic [W-1:0] expRes;
    logic expWr;
    logic expMem;
    string req;
    @(negedge clk);
    opValid = v; opSel = op; memOperand = m; regR = r;
    expRes = '0; expWr = 1'b0; expMem = 1'b0;
    if (v) begin
      case (op)
        3'd0: begin expRes = m + r;  expWr = 1'b1; end
        3'd1: begin expRes = r - m;  expWr = 1'b1; end
        3'd2: begin expRes = m + 16'd1; expWr = 1'b1; expMem = 1'b1; end
        3'd3: begin expRes = m - 16'd1; expWr = 1'b1; expMem = 1'b1; end
        3'd4: begin expRes = '0; expWr = 1'b1; expMem = 1'b1; end
        default: ;
      endcase
    end
    req = reqOf(op, v);
    #1;
    check(req, "result", 32'(result), 32'(expRes));
    check(req, "resValid", 32'(resValid), 32'(expWr));
    check(req, "destIsMem", 32'(destIsMem), 32'(expMem));
    // R6 / R8: flag model updates only on an issued compare
    if (v && op == 3'd5) begin
      expFlags = {($signed(m) > $signed(r)), (m == r), ($signed(m) < $signed(r))};
    end
    @(posedge clk);
    #1;
    check((v && op == 3'd5) ? "R6" : "R8", "flags",
          32'({flagGt, flagEq, flagLt}), 32'(expFlags));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    // R9: reset state
    #(CLK_PERIOD * 2 + 1);
    check("R9", "flags in reset", 32'({flagGt, flagEq, flagLt}), 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    check("R9", "flags after reset", 32'({flagGt, flagEq, flagLt}), 32'd0);

    // full opcode x operand grid, issued
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 10; j++)
          apply(3'(op), sample(i), sample(j), 1'b1);

    // idle cycles with every code must not disturb flags or write (R8, R10)
    apply(3'd5, 16'h8000, 16'h7FFF, 1'b1);
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 10; i++)
        apply(3'(op), sample(i), sample(9 - i), 1'b0);

    // signed boundary compares (R6)
    apply(3'd5, 16'h7FFF, 16'h8000, 1'b1);
    apply(3'd5, 16'hFFFF, 16'h0000, 1'b1);
    apply(3'd5, 16'h0000, 16'hFFFF, 1'b1);

    // asynchronous reset mid-run clears flags (R9)
    @(negedge clk);
    opValid = 1'b0;
    #2 rstN = 1'b0;
    #1;
    expFlags = 3'b000;
    check("R9", "flags after async reset", 32'({flagGt, flagEq, flagLt}), 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    apply(3'd0, 16'h0010, 16'h0020, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule